// File: doc/BRIEF.md
# Mode-Configurable Redundancy Voter

This unit sits between four identical compute sockets and the system bus. A two-bit mode register, written at run time, decides how the sockets are grouped. In quad-lane mode every socket is forwarded on its own lane with no checking. In dual-pair mode the sockets form two self-checking pairs, (0,1) and (2,3), which gives two-way parallelism. In triple mode sockets 0, 1 and 2 are majority-voted and socket 3 is unused. In single-pair mode only sockets 0 and 1 are compared and sockets 2 and 3 are blank.

A self-checking pair only detects a disagreement. The first copy is still forwarded and recovery is left to a supervising processor. In triple mode the output is the bitwise majority of the three copies. The unit also records which single socket was outvoted, so the faulty copy can be identified while the output stays correct. Every detected fault lands in a sticky error status register that software clears by writing ones. All outputs are registered with one cycle of latency.

A small controller holds the mode register and has two states: `ST_RUN`, where groups are compared and forwarded, and `ST_SETTLE`, where inputs are ignored for one cycle after a mode write. The transitions are:
- RUN→SETTLE on any mode write.
- SETTLE→SETTLE on another mode write.
- SETTLE→RUN otherwise.
- RUN→RUN while no write occurs.

Top module: `redun_vote_unit`

## Requirements
- R1: After reset `mode_q` is 0 (quad-lane), `out_valid` is 0, `out_data` is 0 and `err_status` is 0.
- R2: Mode code 0 (quad-lane): one cycle after a socket is valid, lane i carries socket i's data with its valid. No error bit is ever set in this mode.
- R3: Mode code 1 (dual-pair): lane p (p=0,1) goes valid one cycle after both sockets 2p and 2p+1 are valid, and carries socket 2p's data. If the two copies differ, the data is still forwarded and status bit p is set. Lanes 2 and 3 stay invalid.
- R4: Mode code 2 (triple): lane 0 goes valid one cycle after sockets 0, 1 and 2 are all valid, and carries the bitwise majority of the three. Socket 3 is ignored, and lanes 1 to 3 stay invalid.
- R5: In triple mode a vote where exactly one socket differs from the other two sets status bit 2 and writes that socket's index into status bits [6:5]. A vote where all three copies differ pairwise sets status bit 3.
- R6: Mode code 3 (single-pair): lane 0 behaves like pair 0 of dual-pair mode, and a mismatch sets bit 0. Sockets 2 and 3 are ignored and can never raise an error. Lanes 1 to 3 stay invalid.
- R7: In any checked mode, a group in which some but not all active sockets are valid produces no output for that group and sets status bit 4.
- R8: Status bits [4:0] are sticky. Pulsing `err_clr` clears each bit whose `err_clr_mask` bit is 1. A fault detected in the same cycle wins over the clear. Clearing bit 2 also zeroes the index field [6:5], unless a new outvote is recorded in that cycle.
- R9: A mode write loads `mode_q` at that edge and clears all lane outputs. The inputs of the write cycle and of the following cycle are ignored (no output, no error). Normal operation resumes on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | New mode code: 0 quad, 1 dual-pair, 2 triple, 3 single-pair |
| mode_q | output | 2 | Current mode code |
| sock_valid | input | 4 | Per-socket result valid |
| sock_data | input | 4*W | Socket results, socket i at bits [i*W +: W] |
| out_valid | output | 4 | Per-lane output valid |
| out_data | output | 4*W | Lane results, lane i at bits [i*W +: W], zero when invalid |
| err_clr | input | 1 | Status clear strobe |
| err_clr_mask | input | 5 | Write-one-to-clear mask for status bits [4:0] |
| err_status | output | 7 | Status: [0] pair 0 mismatch, [1] pair 1 mismatch, [2] outvote, [3] no single outlier, [4] valid disagreement, [6:5] outvoted socket |

## Verification
The checker assumes that every input is a known value at each rising edge after reset. It also assumes that `mode_wdata` and `sock_data` are only meaningful when their strobes or valids are high. Every 2-bit mode code is legal, so no input restriction is needed for the mode-dependent lane properties.

The stimulus drives all inputs on the falling edge. Socket copies are drawn from one base value and then perturbed by occasional single or double bit flips, so matches, single outvotes and three-way disagreements all occur. Valid dropouts, mode writes and status clears are injected at low rates, so both runs of settled operation and back-to-back corner cases appear.

// File: rtl/rvu_pkg.sv
package rvu_pkg;

    localparam int NSOCK  = 4;
    localparam int NPAIR  = NSOCK / 2;
    localparam int IDX_W  = $clog2(NSOCK);
    localparam int FLAG_W = 5;
    localparam int STAT_W = FLAG_W + IDX_W;

    // status flag positions (software decodes these)
    localparam int F_PAIR0  = 0;
    localparam int F_PAIR1  = 1;
    localparam int F_OUTVOT = 2;
    localparam int F_NOMAJ  = 3;
    localparam int F_VALMIS = 4;

    typedef enum logic [1:0] {
        MODE_QUAD   = 2'd0,
        MODE_DUAL   = 2'd1,
        MODE_TRIPLE = 2'd2,
        MODE_SINGLE = 2'd3
    } grp_mode_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_SETTLE = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/rvu_mode_ctrl.sv
module rvu_mode_ctrl
    import rvu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mode_wr,
    input  logic [1:0]  mode_wdata,
    output grp_mode_e   mode_q,
    output logic        capture_en
);

    ctl_state_e state_q, state_d;
    grp_mode_e  mode_d;

    // state and mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            mode_q  <= MODE_QUAD;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d    = state_q;
        mode_d     = mode_q;
        capture_en = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (mode_wr) begin
                    state_d = ST_SETTLE;
                    mode_d  = grp_mode_e'(mode_wdata);
                end else begin
                    capture_en = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (mode_wr) begin
                    mode_d = grp_mode_e'(mode_wdata);
                end else begin
                    state_d = ST_RUN;
                end
            end
        endcase
    end

endmodule

// File: rtl/rvu_pair_cmp.sv
module rvu_pair_cmp #(
    parameter int W = 8
) (
    input  logic         va,
    input  logic         vb,
    input  logic [W-1:0] da,
    input  logic [W-1:0] db,
    output logic         both,
    output logic         partial,
    output logic         differ
);

    always_comb begin
        both    = va & vb;
        partial = va ^ vb;
        differ  = both && (da != db);
    end

endmodule

// File: rtl/rvu_tmr_vote.sv
module rvu_tmr_vote
    import rvu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]       v,
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [W-1:0]     c,
    output logic             all_ok,
    output logic             partial,
    output logic [W-1:0]     maj,
    output logic             outvote,
    output logic [IDX_W-1:0] odd_idx,
    output logic             no_maj
);

    logic eq_ab, eq_ac, eq_bc;

    always_comb begin
        all_ok  = &v;
        partial = (|v) && !(&v);
        maj     = (a & b) | (a & c) | (b & c);
        eq_ab   = (a == b);
        eq_ac   = (a == c);
        eq_bc   = (b == c);
        outvote = 1'b0;
        odd_idx = '0;
        no_maj  = 1'b0;
        if (all_ok) begin
            if (eq_ab && eq_ac) begin
                outvote = 1'b0;
            end else if (eq_ab) begin
                outvote = 1'b1;
                odd_idx = IDX_W'(2);
            end else if (eq_ac) begin
                outvote = 1'b1;
                odd_idx = IDX_W'(1);
            end else if (eq_bc) begin
                outvote = 1'b1;
                odd_idx = IDX_W'(0);
            end else begin
                no_maj = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rvu_err_log.sv
module rvu_err_log
    import rvu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_flags,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic              clr,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status
);

    logic [FLAG_W-1:0] flags_q, flags_d, clr_eff;
    logic [IDX_W-1:0]  idx_q, idx_d;

    always_comb begin
        clr_eff = clr ? clr_mask : '0;
        flags_d = (flags_q & ~clr_eff) | set_flags;
        idx_d   = idx_q;
        if (set_flags[F_OUTVOT]) begin
            idx_d = set_idx;
        end else if (clr_eff[F_OUTVOT]) begin
            idx_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
            idx_q   <= '0;
        end else begin
            flags_q <= flags_d;
            idx_q   <= idx_d;
        end
    end

    assign status = {idx_q, flags_q};

endmodule

// File: rtl/redun_vote_unit.sv
module redun_vote_unit
    import rvu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_wr,
    input  logic [1:0]           mode_wdata,
    output logic [1:0]           mode_q,
    input  logic [NSOCK-1:0]     sock_valid,
    input  logic [NSOCK*W-1:0]   sock_data,
    output logic [NSOCK-1:0]     out_valid,
    output logic [NSOCK*W-1:0]   out_data,
    input  logic                 err_clr,
    input  logic [FLAG_W-1:0]    err_clr_mask,
    output logic [STAT_W-1:0]    err_status
);

    localparam int DW = NSOCK * W;

    grp_mode_e         mode_cur;
    logic              capture_en;
    logic [NPAIR-1:0]  pr_both, pr_part, pr_diff;
    logic              tv_all, tv_part, tv_out, tv_nomaj;
    logic [W-1:0]      tv_maj;
    logic [IDX_W-1:0]  tv_idx;
    logic [NSOCK-1:0]  lane_v;
    logic [DW-1:0]     lane_d;
    logic [FLAG_W-1:0] flags_raw, flags_gated;
    logic [NSOCK-1:0]  ov_q;
    logic [DW-1:0]     od_q;

    rvu_mode_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .mode_q     (mode_cur),
        .capture_en (capture_en)
    );

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        rvu_pair_cmp #(.W(W)) u_cmp (
            .va      (sock_valid[2*p]),
            .vb      (sock_valid[2*p+1]),
            .da      (sock_data[(2*p)*W +: W]),
            .db      (sock_data[(2*p+1)*W +: W]),
            .both    (pr_both[p]),
            .partial (pr_part[p]),
            .differ  (pr_diff[p])
        );
    end

    rvu_tmr_vote #(.W(W)) u_vote (
        .v       (sock_valid[2:0]),
        .a       (sock_data[0 +: W]),
        .b       (sock_data[W +: W]),
        .c       (sock_data[2*W +: W]),
        .all_ok  (tv_all),
        .partial (tv_part),
        .maj     (tv_maj),
        .outvote (tv_out),
        .odd_idx (tv_idx),
        .no_maj  (tv_nomaj)
    );

    // lane routing and fault flags per grouping
    always_comb begin
        lane_v    = '0;
        lane_d    = '0;
        flags_raw = '0;
        unique case (mode_cur)
            MODE_QUAD: begin
                lane_v = sock_valid;
                lane_d = sock_data;
            end
            MODE_DUAL: begin
                for (int p = 0; p < NPAIR; p++) begin
                    lane_v[p]          = pr_both[p];
                    lane_d[p*W +: W]   = sock_data[(2*p)*W +: W];
                    flags_raw[F_PAIR0 + p] = pr_diff[p];
                end
                flags_raw[F_VALMIS] = |pr_part;
            end
            MODE_TRIPLE: begin
                lane_v[0]           = tv_all;
                lane_d[0 +: W]      = tv_maj;
                flags_raw[F_OUTVOT] = tv_out;
                flags_raw[F_NOMAJ]  = tv_nomaj;
                flags_raw[F_VALMIS] = tv_part;
            end
            MODE_SINGLE: begin
                lane_v[0]           = pr_both[0];
                lane_d[0 +: W]      = sock_data[0 +: W];
                flags_raw[F_PAIR0]  = pr_diff[0];
                flags_raw[F_VALMIS] = pr_part[0];
            end
        endcase
        for (int i = 0; i < NSOCK; i++) begin
            if (!lane_v[i]) begin
                lane_d[i*W +: W] = '0;
            end
        end
    end

    assign flags_gated = capture_en ? flags_raw : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_q <= '0;
            od_q <= '0;
        end else if (capture_en) begin
            ov_q <= lane_v;
            od_q <= lane_d;
        end else begin
            ov_q <= '0;
            od_q <= '0;
        end
    end

    rvu_err_log u_log (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_flags (flags_gated),
        .set_idx   (tv_idx),
        .clr       (err_clr),
        .clr_mask  (err_clr_mask),
        .status    (err_status)
    );

    assign mode_q    = mode_cur;
    assign out_valid = ov_q;
    assign out_data  = od_q;

endmodule

// File: rtl/rvu_chk.sv
module rvu_chk
    import rvu_pkg::*;
#(
    parameter int W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mode_wr,
    input logic [1:0]         mode_q,
    input logic [3*W-1:0]     vote_data,
    input logic [NSOCK-1:0]   out_valid,
    input logic [W-1:0]       lane0_data,
    input logic               err_clr,
    input logic [STAT_W-1:0]  err_status
);

    logic [W-1:0] exp_maj;
    assign exp_maj = (vote_data[0 +: W] & vote_data[W +: W])
                   | (vote_data[0 +: W] & vote_data[2*W +: W])
                   | (vote_data[W +: W] & vote_data[2*W +: W]);

    AST_QUAD_NO_NEW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_QUAD) |=> ((err_status & ~$past(err_status)) == '0)); // R2

    AST_DUAL_UPPER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_DUAL) |=> (out_valid[3:2] == 2'b00)); // R3

    AST_TRIPLE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_TRIPLE) |=> (out_valid[3:1] == 3'b000)); // R4

    AST_TRIPLE_MAJORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid[0] && $past(mode_q) == MODE_TRIPLE) |-> (lane0_data == $past(exp_maj))); // R4

    AST_IDX_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status[STAT_W-1:FLAG_W] != '0) |-> err_status[F_OUTVOT]); // R5

    AST_SINGLE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SINGLE) |=> (out_valid[3:1] == 3'b000)); // R6

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> (($past(err_status[FLAG_W-1:0]) & ~err_status[FLAG_W-1:0]) == '0)); // R8

    AST_MODE_WR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> (out_valid == '0)); // R9

    AST_MODE_WR_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> ##1 (out_valid == '0)); // R9

endmodule

bind redun_vote_unit rvu_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_wr    (mode_wr),
    .mode_q     (mode_q),
    .vote_data  (sock_data[3*W-1:0]),
    .out_valid  (out_valid),
    .lane0_data (out_data[W-1:0]),
    .err_clr    (err_clr),
    .err_status (err_status)
);

// File: tb/tb_redun_vote_unit.sv
module tb_redun_vote_unit;

    localparam int W  = 8;
    localparam int DW = 4 * W;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          mode_wr;
    logic [1:0]    mode_wdata, mode_q;
    logic [3:0]    sock_valid, out_valid;
    logic [DW-1:0] sock_data, out_data;
    logic          err_clr;
    logic [4:0]    err_clr_mask;
    logic [6:0]    err_status;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 0;

    // reference model state
    logic [1:0]    m_mode;
    logic          m_settle;
    logic [3:0]    e_ov;
    logic [DW-1:0] e_od;
    logic [6:0]    e_esr;

    redun_vote_unit #(.W(W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr      (mode_wr),
        .mode_wdata   (mode_wdata),
        .mode_q       (mode_q),
        .sock_valid   (sock_valid),
        .sock_data    (sock_data),
        .out_valid    (out_valid),
        .out_data     (out_data),
        .err_clr      (err_clr),
        .err_clr_mask (err_clr_mask),
        .err_status   (err_status)
    );

    function automatic logic [W-1:0] sd(input logic [DW-1:0] d, input int i);
        return d[i*W +: W];
    endfunction

    function automatic logic [W-1:0] vote3(input logic [W-1:0] a, b, c);
        logic [W-1:0] r;
        for (int k = 0; k < W; k++) r[k] = (int'(a[k]) + int'(b[k]) + int'(c[k])) >= 2;
        return r;
    endfunction

    task automatic model_edge();
        logic [4:0] set, clr, fl;
        logic [1:0] idx;
        logic [W-1:0] a, b, c;
        set = '0; idx = e_esr[6:5];
        e_ov = '0; e_od = '0;
        a = sd(sock_data, 0); b = sd(sock_data, 1); c = sd(sock_data, 2);
        if (mode_wr) begin
            m_mode = mode_wdata; m_settle = 1'b1;
        end else if (m_settle) begin
            m_settle = 1'b0;
        end else begin
            case (m_mode)
                2'd0: begin e_ov = sock_valid; e_od = sock_data; end
                2'd1, 2'd3: begin
                    for (int p = 0; p < ((m_mode == 2'd1) ? 2 : 1); p++) begin
                        if (sock_valid[2*p] && sock_valid[2*p+1]) begin
                            e_ov[p] = 1'b1;
                            e_od[p*W +: W] = sd(sock_data, 2*p);
                            if (sd(sock_data, 2*p) != sd(sock_data, 2*p+1)) set[p] = 1'b1;
                        end else if (sock_valid[2*p] != sock_valid[2*p+1]) begin
                            set[4] = 1'b1;
                        end
                    end
                end
                default: begin
                    if (sock_valid[2:0] == 3'b111) begin
                        e_ov[0] = 1'b1;
                        e_od[0 +: W] = vote3(a, b, c);
                        if (a == b && b == c) ;
                        else if (a == b) begin set[2] = 1'b1; idx = 2'd2; end
                        else if (a == c) begin set[2] = 1'b1; idx = 2'd1; end
                        else if (b == c) begin set[2] = 1'b1; idx = 2'd0; end
                        else set[3] = 1'b1;
                    end else if (sock_valid[2:0] != 3'b000) begin
                        set[4] = 1'b1;
                    end
                end
            endcase
            for (int i = 0; i < 4; i++) if (!e_ov[i]) e_od[i*W +: W] = '0;
        end
        clr = err_clr ? err_clr_mask : 5'd0;
        fl  = (e_esr[4:0] & ~clr) | set;
        if (!set[2] && clr[2]) idx = 2'd0;
        e_esr = {idx, fl};
    endtask

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag, "mode_q", 64'(mode_q), 64'(m_mode));
        chk(tag, "out_valid", 64'(out_valid), 64'(e_ov));
        chk(tag, "out_data", 64'(out_data), 64'(e_od));
        chk(tag, "err_status", 64'(err_status), 64'(e_esr));
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all(tag);
        mode_wr = 1'b0; err_clr = 1'b0; err_clr_mask = '0;
    endtask

    task automatic drive(input logic [3:0] v, input logic [W-1:0] d0, d1, d2, d3);
        sock_valid = v;
        sock_data  = {d3, d2, d1, d0};
    endtask

    task automatic set_mode(input logic [1:0] m, input string tag);
        mode_wr = 1'b1; mode_wdata = m;
        drive(4'hF, 8'h11, 8'h22, 8'h33, 8'h44);
        step(tag);
        step(tag); // settle cycle: inputs still ignored
    endtask

    // watchdog
    initial begin
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h00C0FFEE);
        rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = '0;
        sock_valid = '0; sock_data = '0; err_clr = 1'b0; err_clr_mask = '0;
        m_mode = '0; m_settle = 1'b0; e_ov = '0; e_od = '0; e_esr = '0;
        repeat (3) @(negedge clk);
        compare_all("R1"); // reset state
        rst_n = 1'b1;

        // R2: quad lanes forward independently, differing data never flags
        drive(4'hF, 8'hA1, 8'hB2, 8'hC3, 8'hD4); step("R2");
        drive(4'b0101, 8'h01, 8'hFF, 8'h7E, 8'h00); step("R2");
        drive(4'b1010, 8'h5A, 8'h5B, 8'h5C, 8'h5D); step("R2");

        // R9 + R3: dual pairs
        set_mode(2'd1, "R9");
        drive(4'hF, 8'h3C, 8'h3C, 8'h99, 8'h99); step("R3");
        drive(4'hF, 8'h3C, 8'h3D, 8'h99, 8'h99); step("R3");   // pair 0 mismatch
        drive(4'hF, 8'h10, 8'h10, 8'h20, 8'hA0); step("R3");   // pair 1 mismatch
        drive(4'b1101, 8'h10, 8'h10, 8'h20, 8'h20); step("R7"); // pair 0 partial

        // R8: write-one-to-clear, selective
        err_clr = 1'b1; err_clr_mask = 5'b00001;
        drive(4'h0, 8'h0, 8'h0, 8'h0, 8'h0); step("R8");
        err_clr = 1'b1; err_clr_mask = 5'b11111; step("R8");

        // R4 / R5: triple vote, socket 3 ignored
        set_mode(2'd2, "R9");
        drive(4'hF, 8'h66, 8'h66, 8'h66, 8'hFF); step("R4");
        drive(4'h7, 8'h66, 8'h66, 8'h67, 8'h00); step("R5");  // socket 2 outvoted
        drive(4'h7, 8'h80, 8'h81, 8'h80, 8'h00); step("R5");  // socket 1 outvoted
        drive(4'h7, 8'hF0, 8'h0F, 8'h0F, 8'h00); step("R5");  // socket 0 outvoted
        drive(4'h7, 8'h01, 8'h02, 8'h04, 8'h00); step("R5");  // no single outlier
        drive(4'b1011, 8'h01, 8'h01, 8'h01, 8'h01); step("R7");
        drive(4'b1000, 8'h01, 8'h02, 8'h03, 8'h04); step("R4"); // only socket 3
        // set wins over clear in the same cycle
        err_clr = 1'b1; err_clr_mask = 5'b00100;
        drive(4'h7, 8'h44, 8'h45, 8'h45, 8'h00); step("R8");
        err_clr = 1'b1; err_clr_mask = 5'b00100;
        drive(4'h0, 8'h0, 8'h0, 8'h0, 8'h0); step("R8");       // idx cleared with bit 2
        err_clr = 1'b1; err_clr_mask = 5'b11111; step("R8");

        // R6: single pair, blank sockets ignored
        set_mode(2'd3, "R9");
        drive(4'b0111, 8'h21, 8'h21, 8'hEE, 8'h00); step("R6");
        drive(4'b1011, 8'h21, 8'h20, 8'h11, 8'h22); step("R6");
        drive(4'b0100, 8'h00, 8'h00, 8'h55, 8'h66); step("R6");
        // back-to-back mode writes
        mode_wr = 1'b1; mode_wdata = 2'd1; drive(4'hF, 8'h1, 8'h2, 8'h3, 8'h4); step("R9");
        mode_wr = 1'b1; mode_wdata = 2'd0; step("R9");
        step("R9");
        step("R2");

        // constrained random
        for (int n = 0; n < 3000; n++) begin
            logic [W-1:0] base;
            logic [W-1:0] cp [4];
            base = W'($urandom);
            for (int i = 0; i < 4; i++) cp[i] = base;
            if ($urandom_range(3) == 0) cp[$urandom_range(3)][$urandom_range(W-1)] ^= 1'b1;
            if ($urandom_range(15) == 0) cp[$urandom_range(3)][$urandom_range(W-1)] ^= 1'b1;
            for (int i = 0; i < 4; i++) sock_valid[i] = ($urandom_range(7) != 0);
            sock_data = {cp[3], cp[2], cp[1], cp[0]};
            if ($urandom_range(39) == 0) begin
                mode_wr = 1'b1; mode_wdata = 2'($urandom_range(3));
            end
            if ($urandom_range(9) == 0) begin
                err_clr = 1'b1; err_clr_mask = 5'($urandom_range(31));
            end
            step("R8");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule